// File: doc/BRIEF.md
# Timer Input Capture Channel

This block timestamps falling edges on an asynchronous input pin. A free-running 16-bit count advances once every four bus clocks. When a high-to-low transition on the capture pin has passed through a two-stage synchronizer, the channel stores the count plus one in a capture register. The register has no reset. A CPU reads it as two byte-wide read-only locations, one for the high byte and one for the low byte.

Each accepted capture sets a status flag. An interrupt request is raised while that flag is set and the enable input is high. The flag is cleared by reading the status location while the flag is set and then reading the low byte. Reading the high byte locks the register: further edges are dropped until the low byte is read, so a two-read sequence always returns one coherent 16-bit value.

The read port is a plain single-cycle strobe with no back-pressure. Read data is combinational in the strobe cycle, and every side effect of a read takes place at the clock edge that ends that cycle. The pin, the enable and the interrupt are plain level signals.

Top module: `tcap_unit`

## Requirements
- R1: Only a high-to-low transition of the capture pin causes a capture. A low-to-high transition leaves the register and the flag unchanged.
- R2: A read strobe at address 0x1C returns bits 15:8 of the capture register, and one at address 0x1D returns bits 7:0.
- R3: The value stored is one more than the count that is current in the cycle the synchronized fall is detected. It becomes readable two clocks after the first clock edge that samples the pin low.
- R4: The count resets to 0xFFFC and increases by one every four clocks, wrapping from 0xFFFF to 0x0000. After N clocks out of reset it equals 0xFFFC + floor(N/4) mod 65536.
- R5: An accepted capture sets the flag, which reads as bit 7 of address 0x13. The other bits of that address read 0. Reset clears the flag.
- R6: irq is high exactly when the flag is set and cap_ie is high.
- R7: A capture overwrites the register whether the flag is set or clear, so the register holds the most recent accepted capture.
- R8: After a read at 0x1C, falling edges do not change the register and do not set the flag until a read at 0x1D. An edge dropped in that window is not replayed later.
- R9: A read at 0x1D on its own does not block the captures that follow it.
- R10: The flag clears at a read of 0x1D only if a read of 0x13 saw the flag set since the last read of 0x1D. A read of 0x1D without that earlier status read leaves the flag set. A capture in the same cycle keeps the flag set.
- R11: Reset leaves the capture register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input, falling edge active |
| cap_ie | input | 1 | Capture interrupt enable |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt request |

## Verification
The first clock edge that samples the pin low is edge k. The new value and the flag are both due after edge k+2. The driver therefore computes its expected value from its own clock count right after edge k+1 and queues it, and reads start only once edge k+2 has passed. Read data is sampled 1 ns into the strobe cycle. Lock and flag-clear effects are taken to apply from the next cycle on. The interrupt is sampled 1 ns after cap_ie changes, since it follows the flag and the enable with no register in between.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 8;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h13;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 8'h1C;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 8'h1D;
  localparam int unsigned FLAG_BIT = 7;
endpackage

// File: rtl/tcap_freerun.sv
module tcap_freerun #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRE_DIV = 4,
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] DIV_LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0]    div_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= RST_VAL;
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      cnt_q <= cnt_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/tcap_fall_sync.sv
module tcap_fall_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              hist_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= pin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b1;
    else        hist_q <= chain_q[STAGES-1];
  end

  assign fall_o = hist_q & ~chain_q[STAGES-1];

  assert_fall_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tcap_latch.sv
module tcap_latch #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rd_hi_i,
  input  logic             rd_lo_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             take_o
);
  logic [CNT_W-1:0] cap_q;
  logic             lock_q;
  logic             block;

  assign block  = lock_q | rd_hi_i;
  assign take_o = fall_i & ~block;

  always_ff @(posedge clk) begin
    if (take_o) cap_q <= CNT_W'(cnt_i + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (rd_hi_i) lock_q <= 1'b1;
    else if (rd_lo_i) lock_q <= 1'b0;
  end

  assign cap_o = cap_q;

  logic filled_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      filled_q <= 1'b0;
    else if (take_o) filled_q <= 1'b1;
  end

  assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (filled_q && lock_q && !rd_lo_i) |=> $stable(cap_q));

  assert_value_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> cap_q == CNT_W'($past(cnt_i) + 1'b1));
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int unsigned CNT_W   = 2 * DATA_W,
  parameter int unsigned PRE_DIV = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [CNT_W-1:0] CNT_RST = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_pin,
  input  logic              cap_ie,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cap;
  logic             fall;
  logic             take;
  logic             rd_hi, rd_lo, rd_st;
  logic             flag_q, arm_q;

  assign rd_hi = rd_en && (rd_addr == ADDR_HI);
  assign rd_lo = rd_en && (rd_addr == ADDR_LO);
  assign rd_st = rd_en && (rd_addr == ADDR_STAT);

  tcap_freerun #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV), .RST_VAL(CNT_RST)) i_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_o(cnt));

  tcap_fall_sync #(.STAGES(STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_pin), .fall_o(fall));

  tcap_latch #(.CNT_W(CNT_W)) i_latch (
    .clk(clk), .rst_n(rst_n), .fall_i(fall), .cnt_i(cnt),
    .rd_hi_i(rd_hi), .rd_lo_i(rd_lo), .cap_o(cap), .take_o(take));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (take)                flag_q <= 1'b1;
      else if (rd_lo && arm_q) flag_q <= 1'b0;
      if (rd_lo)      arm_q <= 1'b0;
      else if (rd_st) arm_q <= flag_q;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_hi)      rd_data = cap[CNT_W-1 -: DATA_W];
    else if (rd_lo) rd_data = cap[DATA_W-1:0];
    else if (rd_st) rd_data[FLAG_BIT] = flag_q;
  end

  assign irq = flag_q & cap_ie;

  assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(take));

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(rd_lo && arm_q));

  assert_take_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> fall);
endmodule

// File: tb/test_tcap_unit.sv
module test_tcap_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_pin = 1'b1;
  logic       cap_ie = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  int total = 0;
  int bad = 0;
  int edges = 0;
  bit done = 1'b0;
  logic [15:0] last_cap = 16'h0000;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  tcap_unit i_tcap_unit (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .cap_ie(cap_ie),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = a;
    #1 d = rd_data;
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cap_fall(input bit accept);
    logic [15:0] e;
    @(negedge clk);
    cap_pin = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1 e = 16'((32'hFFFC + edges / 4 + 1) & 32'hFFFF);
    if (accept) begin
      exp_q.push_back(e);
      last_cap = e;
    end
    @(posedge clk);
    idle(2);
  endtask

  task automatic pin_high();
    @(negedge clk);
    cap_pin = 1'b1;
    idle(5);
  endtask

  task automatic sb_read(input string req);
    logic [7:0] h, l;
    logic [15:0] e;
    rd(8'h1C, h);
    rd(8'h1D, l);
    while (exp_q.size() > 1) void'(exp_q.pop_front());
    e = (exp_q.size() == 1) ? exp_q.pop_front() : last_cap;
    check(req, {h, l}, e);
  endtask

  task automatic chk_flag(input string req, input bit exp);
    logic [7:0] s;
    rd(8'h13, s);
    check(req, {8'h00, s}, {8'h00, exp, 7'b0});
  endtask

  task automatic clear_flag();
    logic [7:0] d;
    rd(8'h13, d);
    rd(8'h1D, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] d;
    idle(3);
    rst_n = 1'b1;
    #1 check("R6 reset irq", {15'b0, irq}, 16'h0);
    chk_flag("R5 reset flag", 1'b0);

    cap_fall(1'b1);
    pin_high();
    chk_flag("R5 flag set", 1'b1);
    #1 check("R6 irq masked", {15'b0, irq}, 16'h0);
    cap_ie = 1'b1;
    #1 check("R6 irq enabled", {15'b0, irq}, 16'h1);
    sb_read("R3 R4 wrap value R2");
    chk_flag("R10 cleared", 1'b0);
    #1 check("R6 irq after clear", {15'b0, irq}, 16'h0);

    cap_fall(1'b1);
    clear_flag();
    sb_read("R3 second value");
    pin_high();
    chk_flag("R1 rise no flag", 1'b0);
    sb_read("R1 rise no capture");

    cap_fall(1'b1);
    pin_high();
    cap_fall(1'b1);
    pin_high();
    sb_read("R7 overwrite");
    chk_flag("R7 flag set", 1'b1);
    clear_flag();

    rd(8'h1C, d);
    check("R8 hi byte", {8'h00, d}, {8'h00, last_cap[15:8]});
    cap_fall(1'b0);
    pin_high();
    chk_flag("R8 dropped no flag", 1'b0);
    rd(8'h1D, d);
    check("R8 coherent lo", {8'h00, d}, {8'h00, last_cap[7:0]});
    idle(6);
    chk_flag("R8 not replayed flag", 1'b0);
    sb_read("R8 not replayed value");

    rd(8'h1D, d);
    cap_fall(1'b1);
    pin_high();
    sb_read("R9 lo only no block");
    clear_flag();

    cap_fall(1'b1);
    pin_high();
    rd(8'h1D, d);
    chk_flag("R10 lo alone keeps flag", 1'b1);
    rd(8'h1D, d);
    chk_flag("R10 status then lo clears", 1'b0);

    do_reset();
    chk_flag("R5 flag after reset", 1'b0);
    sb_read("R11 value kept over reset");
    idle(40);
    cap_fall(1'b1);
    pin_high();
    sb_read("R4 count after reset");
    idle(100);
    cap_fall(1'b1);
    pin_high();
    sb_read("R4 count later");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule